// File: doc/BRIEF.md
# Real-Time Clock Interrupt Generator

This block produces the two interrupt requests of a real-time clock. A time base comes either from an internal prescaler or from an external frequency input. The prescaler divides the system clock by a programmable divisor, typically set for a rate between 100 Hz and 10 kHz. The external input is synchronised, and each of its rising edges counts as one tick. Every time-base tick raises the first request, which asks the processor to increment a designated count word in memory. The memory transfer itself happens elsewhere.

The block keeps a shadow copy of that count. On the tick that takes the count to 40,000, it raises the second request, and in the same cycle the shadow count returns to zero. Each request stays asserted until its acknowledge arrives. If a new event for a source arrives while that source's request is still pending, a per-source lost flag is set, and that flag also clears on acknowledge.

Top module: `rtc_irq_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_req`, `irq_lost` and `count_val` all become zero.
- R2: With `enable`=1 and `ext_sel`=0, a time-base tick occurs once every D clock cycles, where D is `div_value` and a divisor of 0 acts as 1. The first tick after `enable` rises makes `count_val` read 1 after D+1 clock edges.
- R3: With `enable`=1 and `ext_sel`=1, each rising edge of `ext_tick_in` gives exactly one tick. The effect shows at the third clock edge after the input goes high. Holding the input high gives no further ticks.
- R4: Each tick increments `count_val` by one and sets `irq_req[0]`, which is the time-base request.
- R5: On the tick that would take the count to the terminal value (default 40,000), `count_val` becomes 0 and `irq_req[1]`, which is the count-reached request, is set at the same edge.
- R6: A request stays high until its bit of `irq_ack` is sampled high. It then drops at that edge, unless a new event for the same source arrives in the same cycle, in which case it stays high.
- R7: An event for a source whose request is pending and not being acknowledged sets that source's bit of `irq_lost`. The bit clears when the same acknowledge bit is sampled high.
- R8: While `enable` is low, no ticks occur. `count_val` and the pending requests keep their values, and the prescaler restarts its period when `enable` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows time-base ticks |
| div_value | input | DIV_W | Prescaler divisor (0 acts as 1) |
| ext_sel | input | 1 | 1 selects the external tick input as the time base |
| ext_tick_in | input | 1 | Asynchronous external frequency input |
| irq_ack | input | 2 | Acknowledges: bit 0 time-base, bit 1 count-reached |
| irq_req | output | 2 | Requests: bit 0 time-base, bit 1 count-reached |
| irq_lost | output | 2 | Lost-event flags, per source |
| count_val | output | CNT_W | Shadow of the count word |

## Verification
With the internal source, the first tick lands D edges after `enable` is sampled high, and its count and request show one edge later. An external edge shows three edges after the input rises, because of two synchroniser flops and the request register. Acknowledges and count wraps act at the very edge that samples them. A behavioural reference model steps at each rising edge from the same inputs, and every output is compared at the following falling edge. Directed checks count falling edges from a drive made just after a falling edge, so that each expected value is read in exactly the cycle it becomes due.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_SRC    = 2;
    localparam int SRC_BASE   = 0;
    localparam int SRC_TERM   = 1;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        TB_INTERNAL = 1'b0,
        TB_EXTERNAL = 1'b1
    } tb_src_e;

    // events produced in one cycle
    typedef struct packed {
        logic wrap;
        logic tick;
    } rtc_evt_t;

    function automatic logic [NUM_SRC-1:0] evt_to_vec(input rtc_evt_t e);
        logic [NUM_SRC-1:0] v;
        v[SRC_BASE] = e.tick;
        v[SRC_TERM] = e.wrap;
        return v;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_value,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last_idx;
    logic             tick_q;

    // a divisor of zero behaves as one
    assign last_idx = (div_value == '0) ? '0 : div_value - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
            tick_q  <= 1'b0;
        end else if (phase_q >= last_idx) begin
            phase_q <= '0;
            tick_q  <= 1'b1;
        end else begin
            phase_q <= phase_q + 1'b1;
            tick_q  <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick_o);

endmodule

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R3
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/rtc_count_shadow.sv
module rtc_count_shadow #(
    parameter int TERM_COUNT = 40000,
    localparam int CNT_W     = $clog2(TERM_COUNT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    output logic             wrap_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_COUNT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = tick_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (wrap_o) cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> ((cnt_q == CNT_W'($past(cnt_q) + 1'b1)) ||
                             (cnt_q == '0 && $past(cnt_q) == LAST)));

endmodule

// File: rtl/rtc_req_latch.sv
module rtc_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic event_i,
    input  logic ack_i,
    output logic req_o,
    output logic lost_o
);
    logic req_q;
    logic lost_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            lost_q <= 1'b0;
        end else begin
            // a new event wins over a simultaneous acknowledge
            req_q  <= event_i | (req_q & ~ack_i);
            lost_q <= ~ack_i & (lost_q | (event_i & req_q));
        end
    end

    assign req_o  = req_q;
    assign lost_o = lost_q;

    // R6
    req_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(req_q) |-> $past(ack_i));

    // R7
    lost_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_q) |-> ($past(req_q) && $past(event_i)));

endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
    import rtc_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int TERM_COUNT  = 40000,
    localparam int CNT_W      = $clog2(TERM_COUNT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [DIV_W-1:0]   div_value,
    input  logic               ext_sel,
    input  logic               ext_tick_in,
    input  logic [NUM_SRC-1:0] irq_ack,
    output logic [NUM_SRC-1:0] irq_req,
    output logic [NUM_SRC-1:0] irq_lost,
    output logic [CNT_W-1:0]   count_val
);
    tb_src_e            src_sel;
    logic               int_tick;
    logic               ext_rise;
    rtc_evt_t           evt;
    logic [NUM_SRC-1:0] evt_vec;

    assign src_sel = ext_sel ? TB_EXTERNAL : TB_INTERNAL;

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .run       (enable && src_sel == TB_INTERNAL),
        .div_value (div_value),
        .tick_o    (int_tick)
    );

    rtc_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (ext_tick_in),
        .rise_o (ext_rise)
    );

    always_comb begin
        evt.tick = 1'b0;
        if (enable) begin
            unique case (src_sel)
                TB_INTERNAL: evt.tick = int_tick;
                TB_EXTERNAL: evt.tick = ext_rise;
                default:     evt.tick = 1'b0;
            endcase
        end
    end

    rtc_count_shadow #(.TERM_COUNT(TERM_COUNT)) u_count (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (evt.tick),
        .wrap_o  (evt.wrap),
        .count_o (count_val)
    );

    assign evt_vec = evt_to_vec(evt);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rtc_req_latch u_latch (
            .clk     (clk),
            .rst     (rst),
            .event_i (evt_vec[s]),
            .ack_i   (irq_ack[s]),
            .req_o   (irq_req[s]),
            .lost_o  (irq_lost[s])
        );
    end

    // R5
    term_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req[SRC_TERM]) |-> (count_val == '0));

    // R8
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(count_val));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (irq_req == '0 && irq_lost == '0 && count_val == '0));

endmodule

// File: tb/tb_rtc_irq_gen.sv
`timescale 1ns/1ps
module tb_rtc_irq_gen;
    localparam int TERM = 40000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [15:0] div = 16'd1;
    logic        ext_sel = 1'b0;
    logic        ext_in = 1'b0;
    logic [1:0]  ack = 2'b00;
    logic [1:0]  req;
    logic [1:0]  lost;
    logic [15:0] cnt;

    int n_total = 0;
    int n_bad   = 0;

    always #5 clk = ~clk;

    rtc_irq_gen dut (
        .clk(clk), .rst(rst), .enable(enable), .div_value(div),
        .ext_sel(ext_sel), .ext_tick_in(ext_in), .irq_ack(ack),
        .irq_req(req), .irq_lost(lost), .count_val(cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int       m_phase;
    bit       m_pt;
    int       m_cnt;
    bit [1:0] m_req, m_lost;
    bit [2:0] m_hist;

    always @(posedge clk) begin
        bit tk, wr;
        int lim;
        if (rst) begin
            m_phase = 0; m_pt = 0; m_cnt = 0; m_req = 0; m_lost = 0; m_hist = 0;
        end else begin
            tk  = enable && (ext_sel ? (m_hist[1] && !m_hist[2]) : m_pt);
            lim = (div == 0) ? 1 : int'(div);
            if (enable && !ext_sel) begin
                m_phase = m_phase + 1;
                m_pt    = (m_phase >= lim);
                if (m_pt) m_phase = 0;
            end else begin
                m_phase = 0; m_pt = 0;
            end
            wr = tk && (m_cnt == TERM - 1);
            if (tk) m_cnt = wr ? 0 : m_cnt + 1;
            for (int i = 0; i < 2; i++) begin
                bit ev;
                ev = (i == 0) ? tk : wr;
                m_lost[i] = !ack[i] && (m_lost[i] || (ev && m_req[i]));
                m_req[i]  = ev || (m_req[i] && !ack[i]);
            end
            m_hist = {m_hist[1:0], ext_in};
        end
    end

    bit model_on = 1'b0;
    always @(negedge clk) begin
        if (model_on) begin
            check(cnt == m_cnt[15:0], "R4 model count", cnt, m_cnt);
            check(req[0] == m_req[0], "R6 model base request", req[0], m_req[0]);
            check(req[1] == m_req[1], "R5 model term request", req[1], m_req[1]);
            check(lost == m_lost, "R7 model lost flags", lost, m_lost);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst = 1'b1; enable = 1'b0; ext_sel = 1'b0; ext_in = 1'b0; ack = 2'b00;
        wait_n(2);
        rst = 1'b0;
    endtask

    initial begin
        int c0;
        wait_n(2);
        model_on = 1'b1;
        // R1 reset state
        check(req == 2'b00, "R1 req after reset", req, 0);
        check(lost == 2'b00, "R1 lost after reset", lost, 0);
        check(cnt == 16'd0, "R1 count after reset", cnt, 0);

        // R2 internal divisor 4
        do_reset();
        div = 16'd4; enable = 1'b1;
        wait_n(4);
        check(cnt == 16'd0, "R2 no tick before D+1 edges", cnt, 0);
        wait_n(1);
        check(cnt == 16'd1, "R2 first tick at D+1 edges", cnt, 1);
        check(req[0] == 1'b1, "R4 base request set", req[0], 1);
        wait_n(3);
        check(cnt == 16'd1, "R2 period not shorter", cnt, 1);
        wait_n(1);
        check(cnt == 16'd2, "R2 second tick after D", cnt, 2);
        check(lost[0] == 1'b1, "R7 lost on unacked tick", lost[0], 1);
        // R6 acknowledge clears request and lost flag
        ack = 2'b01;
        wait_n(1);
        ack = 2'b00;
        check(req[0] == 1'b0, "R6 ack clears request", req[0], 0);
        check(lost[0] == 1'b0, "R7 ack clears lost", lost[0], 0);

        // R2 divisor zero acts as one
        do_reset();
        div = 16'd0; enable = 1'b1;
        wait_n(11);
        check(cnt == 16'd10, "R2 divisor 0 ticks every cycle", cnt, 10);

        // R8 disable holds state
        enable = 1'b0; div = 16'd2;
        c0 = cnt;
        wait_n(30);
        check(cnt == c0[15:0], "R8 count held while disabled", cnt, c0);
        check(req[0] == 1'b1, "R8 request held while disabled", req[0], 1);
        enable = 1'b1;
        wait_n(2);
        check(cnt == c0[15:0], "R8 prescaler restarts", cnt, c0);
        wait_n(1);
        check(cnt == c0[15:0] + 16'd1, "R8 first tick after restart", cnt, c0 + 1);

        // R3 external source
        do_reset();
        ext_sel = 1'b1; enable = 1'b1;
        wait_n(4);
        ext_in = 1'b1;
        wait_n(2);
        check(cnt == 16'd0, "R3 not before third edge", cnt, 0);
        wait_n(1);
        check(cnt == 16'd1, "R3 tick at third edge", cnt, 1);
        wait_n(20);
        check(cnt == 16'd1, "R3 level gives one tick", cnt, 1);
        // R6 new tick with ack in same cycle keeps request
        ext_in = 1'b0;
        wait_n(5);
        ext_in = 1'b1;
        wait_n(2);
        ack = 2'b01;
        wait_n(1);
        ack = 2'b00;
        check(req[0] == 1'b1, "R6 event wins over ack", req[0], 1);
        check(lost[0] == 1'b0, "R7 no loss when acked", lost[0], 0);
        check(cnt == 16'd2, "R3 second edge counted", cnt, 2);

        // R5 terminal count with divisor 1
        do_reset();
        ext_sel = 1'b0; div = 16'd1; enable = 1'b1;
        wait_n(TERM);
        check(cnt == 16'(TERM - 1), "R5 count before wrap", cnt, TERM - 1);
        check(req[1] == 1'b0, "R5 no term request yet", req[1], 0);
        wait_n(1);
        check(cnt == 16'd0, "R5 count wraps to zero", cnt, 0);
        check(req[1] == 1'b1, "R5 term request raised", req[1], 1);
        enable = 1'b0;
        ack = 2'b10;
        wait_n(1);
        ack = 2'b00;
        check(req[1] == 1'b0, "R6 term ack clears", req[1], 0);
        wait_n(2);

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_total++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule